// File: doc/BRIEF.md
# Vector Word Divide, Modulo and Multiply-High Unit

This block is a multicycle SIMD integer engine for 128-bit vector operands. Each operand holds four 32-bit lanes, and one opcode applies a single operation to all four. The operations are truncating divide, remainder-style modulo, extended divide and multiply-high, each in an unsigned and a signed form. An 11-bit secondary opcode selects the operation. A one-cycle start pulse hands the unit the opcode and both operands. A one-cycle done pulse marks the moment the 128-bit result is ready.

Inside, the lanes are processed one after the other. A single iterative 64-by-64 restoring divider works on operand magnitudes. A single multiplier serves the multiply-high operations and rebuilds the modulo result as A minus quotient times B. Lane operands are zero- or sign-extended to 64 bits before any arithmetic. For extended divides, the dividend lane is moved into the upper half of a 64-bit dividend.

Top module: `vwdiv_unit`

## Requirements
- R1: Opcode 0x08B gives the unsigned quotient and 0x18B the signed quotient truncated toward zero, per lane. Lane i is bits 32*i+31 down to 32*i of A, B and the result.
- R2: Opcode 0x68B (unsigned) and 0x78B (signed) give A minus (truncated quotient times B) in 32-bit wraparound arithmetic, so a signed remainder takes the dividend's sign.
- R3: Opcode 0x289 (unsigned) and 0x389 (signed) give bits 63..32 of the 64-bit product of the extended lane operands.
- R4: Opcode 0x28B divides A·2^32 by zero-extended B. The lane is zero if the quotient has any set bit at position 32 or above; otherwise it is the low 32 quotient bits.
- R5: Opcode 0x38B divides sign-extended A·2^32 by sign-extended B. The lane is zero if the quotient of the magnitudes has any set bit at position 31 or above; otherwise it is the low 32 bits of the signed quotient.
- R6: A zero divisor lane gives zero for every divide opcode and gives A for modulo. In opcode 0x18B, 0x80000000 divided by 0xFFFFFFFF gives zero. In opcode 0x78B the same operands give zero.
- R7: An accepted start raises busy on the next cycle. Busy stays high until done. Done is a one-cycle pulse, issued with busy already low, and the result holds its value while the unit is idle.
- R8: A start pulse while busy is ignored: the running operation finishes with its own operands and no second operation follows.
- R9: A start carrying any other opcode is ignored: busy stays low and the result keeps its value.
- R10: After reset, busy and done are low and the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request carrying opcode and operands |
| opc_i | input | 11 | Secondary opcode |
| a_i | input | 128 | Operand A, four 32-bit lanes |
| b_i | input | 128 | Operand B, four 32-bit lanes |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse, result valid |
| res_o | output | 128 | Result, four 32-bit lanes |

## Verification
Directed vectors put distinct values in every lane. This shows up lane swaps, sign-handling mistakes and a wrong choice between zero- and sign-extension. The edge operands are 0, 1, all-ones and 0x80000000. They separate the zero-divisor rule, the 0x80000000 by -1 overflow rule and the 32-bit versus 31-bit fit limits of the two extended divides. Constrained-random runs draw all eight opcodes with lane values biased toward these edges, and check them against bench models written in 64-bit integer arithmetic. Starts issued mid-operation and starts with unknown opcodes confirm that neither disturbs the result.

// File: rtl/vwdiv_pkg.sv
package vwdiv_pkg;
  localparam int unsigned OPC_W = 11;

  typedef enum logic [2:0] {
    K_DIVU, K_DIVS, K_MODU, K_MODS, K_MULHU, K_MULHS, K_DIVEU, K_DIVES
  } vop_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_DIV, ST_LANE} vst_e;

  typedef struct packed {
    logic valid;
    vop_e kind;
  } vdec_t;

  function automatic vdec_t decode_opc(input logic [OPC_W-1:0] opc);
    vdec_t d;
    d.valid = 1'b1;
    d.kind  = K_DIVU;
    case (opc)
      11'h08B: d.kind = K_DIVU;
      11'h18B: d.kind = K_DIVS;
      11'h68B: d.kind = K_MODU;
      11'h78B: d.kind = K_MODS;
      11'h289: d.kind = K_MULHU;
      11'h389: d.kind = K_MULHS;
      11'h28B: d.kind = K_DIVEU;
      11'h38B: d.kind = K_DIVES;
      default: d.valid = 1'b0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/vwdiv_divider.sv
module vwdiv_divider #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CW = $clog2(W + 1);

  logic         run_q, run_n;
  logic         done_q, done_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [W-1:0] rem_q, rem_n, quo_q, quo_n, dvs_q, dvs_n;
  logic [W:0]   trial, diff;

  always_comb begin
    run_n  = run_q;
    done_n = 1'b0;
    cnt_n  = cnt_q;
    rem_n  = rem_q;
    quo_n  = quo_q;
    dvs_n  = dvs_q;
    trial  = {rem_q, quo_q[W-1]};
    diff   = trial - {1'b0, dvs_q};
    if (start_i) begin
      run_n = 1'b1;
      cnt_n = CW'(W);
      rem_n = '0;
      quo_n = dividend_i;
      dvs_n = divisor_i;
    end else if (run_q) begin
      if (!diff[W]) begin
        rem_n = diff[W-1:0];
        quo_n = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_n = trial[W-1:0];
        quo_n = {quo_q[W-2:0], 1'b0};
      end
      cnt_n = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
    end else begin
      run_q  <= run_n;
      done_q <= done_n;
      cnt_q  <= cnt_n;
      rem_q  <= rem_n;
      quo_q  <= quo_n;
      dvs_q  <= dvs_n;
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;

  // R7
  div_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !run_q);

  // R7
  div_done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !run_q && $past(run_q));
endmodule

// File: rtl/vwdiv_mul.sv
module vwdiv_mul #(
  parameter int W = 32
) (
  input  logic [W-1:0]   x_i,
  input  logic [W-1:0]   y_i,
  input  logic           sgn_i,
  output logic [2*W-1:0] prod_o
);
  localparam int PW = 2 * W + 2;

  logic [PW-1:0] xe, ye, p;

  always_comb begin
    xe = {{(W + 2){sgn_i & x_i[W-1]}}, x_i};
    ye = {{(W + 2){sgn_i & y_i[W-1]}}, y_i};
    p  = xe * ye;
  end

  assign prod_o = p[2*W-1:0];
endmodule

// File: rtl/vwdiv_lane.sv
module vwdiv_lane
  import vwdiv_pkg::*;
#(
  parameter int LW = 32
) (
  input  vop_e              kind_i,
  input  logic [LW-1:0]     a_i,
  input  logic [LW-1:0]     b_i,
  input  logic [2*LW-1:0]   quot_i,
  input  logic [2*LW-1:0]   prod_i,
  output logic [2*LW-1:0]   dvd_o,
  output logic [2*LW-1:0]   dvs_o,
  output logic [LW-1:0]     mx_o,
  output logic [LW-1:0]     my_o,
  output logic              msgn_o,
  output logic [LW-1:0]     res_o
);
  localparam int DW = 2 * LW;
  localparam logic [LW-1:0] MOST_NEG = {1'b1, {(LW-1){1'b0}}};

  logic          sgn, ext, is_mod, a_neg, b_neg, b_zero, ovf;
  logic [DW-1:0] a_x, a_d, b_x, q_s;
  logic [LW-1:0] q_use;

  always_comb begin
    sgn    = kind_i inside {K_DIVS, K_MODS, K_MULHS, K_DIVES};
    ext    = kind_i inside {K_DIVEU, K_DIVES};
    is_mod = kind_i inside {K_MODU, K_MODS};
    a_x    = sgn ? {{LW{a_i[LW-1]}}, a_i} : {{LW{1'b0}}, a_i};
    a_d    = ext ? {a_i, {LW{1'b0}}} : a_x;
    b_x    = sgn ? {{LW{b_i[LW-1]}}, b_i} : {{LW{1'b0}}, b_i};
    a_neg  = sgn & a_d[DW-1];
    b_neg  = sgn & b_x[DW-1];
    dvd_o  = a_neg ? (~a_d + DW'(1)) : a_d;
    dvs_o  = b_neg ? (~b_x + DW'(1)) : b_x;
    q_s    = (a_neg ^ b_neg) ? (~quot_i + DW'(1)) : quot_i;
    b_zero = (b_i == '0);
    ovf    = sgn && (a_i == MOST_NEG) && (b_i == '1);
    q_use  = b_zero ? '0 : q_s[LW-1:0];
    mx_o   = is_mod ? q_use : a_i;
    my_o   = b_i;
    msgn_o = sgn & ~is_mod;
    case (kind_i)
      K_DIVU, K_DIVS:   res_o = (b_zero || ovf) ? '0 : q_s[LW-1:0];
      K_MODU, K_MODS:   res_o = a_i - prod_i[LW-1:0];
      K_MULHU, K_MULHS: res_o = prod_i[DW-1:LW];
      K_DIVEU:          res_o = (b_zero || (|quot_i[DW-1:LW])) ? '0 : quot_i[LW-1:0];
      K_DIVES:          res_o = (b_zero || (|quot_i[DW-1:LW-1])) ? '0 : q_s[LW-1:0];
      default:          res_o = '0;
    endcase
  end
endmodule

// File: rtl/vwdiv_unit.sv
module vwdiv_unit
  import vwdiv_pkg::*;
#(
  parameter int LW    = 32,
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [OPC_W-1:0]      opc_i,
  input  logic [LW*LANES-1:0]   a_i,
  input  logic [LW*LANES-1:0]   b_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [LW*LANES-1:0]   res_o
);
  localparam int VW  = LW * LANES;
  localparam int DW  = 2 * LW;
  localparam int LIW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [LIW-1:0] LAST = LIW'(LANES - 1);

  vst_e           st_q, st_n;
  vop_e           kind_q, kind_n;
  logic [VW-1:0]  a_q, a_n, b_q, b_n, res_q;
  logic [LIW-1:0] lane_q, lane_n;
  logic           done_q, done_n;
  logic           cap, div_go, div_done, is_mul;
  vdec_t          dec;
  logic [LW-1:0]  a_ln, b_ln, ln_res, mx, my;
  logic [DW-1:0]  dvd, dvs, quot, prod;
  logic           msgn;
  logic [LANES-1:0] lane_we;

  assign dec    = decode_opc(opc_i);
  assign cap    = (st_q == ST_IDLE) && start_i && dec.valid;
  assign is_mul = kind_q inside {K_MULHU, K_MULHS};
  assign a_ln   = a_q[lane_q*LW +: LW];
  assign b_ln   = b_q[lane_q*LW +: LW];

  always_comb begin
    st_n   = st_q;
    kind_n = kind_q;
    a_n    = a_q;
    b_n    = b_q;
    lane_n = lane_q;
    done_n = 1'b0;
    div_go = 1'b0;
    case (st_q)
      ST_IDLE: if (cap) begin
        st_n   = ST_ISSUE;
        kind_n = dec.kind;
        a_n    = a_i;
        b_n    = b_i;
        lane_n = '0;
      end
      ST_ISSUE: begin
        if (is_mul) st_n = ST_LANE;
        else begin
          div_go = 1'b1;
          st_n   = ST_DIV;
        end
      end
      ST_DIV: if (div_done) st_n = ST_LANE;
      ST_LANE: begin
        if (lane_q == LAST) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
        end else begin
          lane_n = lane_q + LIW'(1);
          st_n   = ST_ISSUE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= K_DIVU;
      a_q    <= '0;
      b_q    <= '0;
      lane_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      done_q <= done_n;
      lane_q <= lane_n;
      if (cap) begin
        kind_q <= kind_n;
        a_q    <= a_n;
        b_q    <= b_n;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane_reg
    assign lane_we[g] = (st_q == ST_LANE) && (lane_q == LIW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_q[g*LW +: LW] <= '0;
      else if (lane_we[g]) res_q[g*LW +: LW] <= ln_res;
    end
  end

  vwdiv_lane #(.LW(LW)) u_lane (
    .kind_i(kind_q), .a_i(a_ln), .b_i(b_ln), .quot_i(quot), .prod_i(prod),
    .dvd_o(dvd), .dvs_o(dvs), .mx_o(mx), .my_o(my), .msgn_o(msgn), .res_o(ln_res)
  );

  vwdiv_divider #(.W(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .start_i(div_go), .dividend_i(dvd),
    .divisor_i(dvs), .done_o(div_done), .quot_o(quot)
  );

  vwdiv_mul #(.W(LW)) u_mul (.x_i(mx), .y_i(my), .sgn_i(msgn), .prod_o(prod));

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign res_o  = res_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && $past(busy_o));

  // R7
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(res_o));

  // R8
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(kind_q) && $stable(a_q) && $stable(b_q));

  // R9
  bad_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !dec.valid) |=> !busy_o);
endmodule

// File: tb/vwdiv_unit_tb.sv
module vwdiv_unit_tb;
  localparam int CLK_T = 10;
  localparam int WD_LIMIT = 150000;

  logic         clk, rst_n, start;
  logic [10:0]  opc;
  logic [127:0] a, b;
  logic         busy, done;
  logic [127:0] res;

  int n_chk, n_bad, cyc;
  logic wd_hit;

  vwdiv_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .opc_i(opc),
    .a_i(a), .b_i(b), .busy_o(busy), .done_o(done), .res_o(res)
  );

  initial clk = 1'b0;
  always #(CLK_T / 2) clk = ~clk;

  initial begin
    cyc = 0;
    wd_hit = 1'b0;
  end
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) wd_hit <= 1'b1;
  end

  localparam logic [10:0] OPS [8] = '{11'h08B, 11'h18B, 11'h68B, 11'h78B,
                                     11'h289, 11'h389, 11'h28B, 11'h38B};

  function automatic string tag_of(input logic [10:0] op);
    case (op)
      11'h08B, 11'h18B: return "R1";
      11'h68B, 11'h78B: return "R2";
      11'h289, 11'h389: return "R3";
      11'h28B:          return "R4";
      default:          return "R5";
    endcase
  endfunction

  function automatic logic [31:0] ref_lane(input logic [10:0] op,
                                           input logic [31:0] x, input logic [31:0] y);
    logic [63:0] ux, uy, mx, my, qm, p;
    logic signed [63:0] sx, sy, sq, sp;
    logic [31:0] r;
    ux = {32'b0, x};
    uy = {32'b0, y};
    sx = {{32{x[31]}}, x};
    sy = {{32{y[31]}}, y};
    r  = '0;
    case (op)
      11'h08B: r = (y == 0) ? 32'd0 : x / y;
      11'h18B: begin
        if (y == 0 || (x == 32'h8000_0000 && y == 32'hFFFF_FFFF)) r = '0;
        else begin sq = sx / sy; r = sq[31:0]; end
      end
      11'h68B: r = (y == 0) ? x : x % y;
      11'h78B: begin
        if (y == 0) r = x;
        else begin sq = sx % sy; r = sq[31:0]; end
      end
      11'h289: begin p = ux * uy; r = p[63:32]; end
      11'h389: begin sp = sx * sy; r = sp[63:32]; end
      11'h28B: begin
        if (y == 0) r = '0;
        else begin
          qm = {x, 32'b0} / uy;
          r = (qm[63:32] != 0) ? 32'd0 : qm[31:0];
        end
      end
      default: begin
        if (y == 0) r = '0;
        else begin
          sp = sx <<< 32;
          mx = sp[63] ? (~sp + 64'd1) : sp;
          my = sy[63] ? (~sy + 64'd1) : sy;
          qm = mx / my;
          if ((qm >> 31) != 0) r = '0;
          else begin
            sq = (sp[63] ^ sy[63]) ? (~qm + 64'd1) : qm;
            r = sq[31:0];
          end
        end
      end
    endcase
    return r;
  endfunction

  function automatic logic [127:0] ref_vec(input logic [10:0] op,
                                           input logic [127:0] x, input logic [127:0] y);
    logic [127:0] v;
    for (int i = 0; i < 4; i++) v[32*i +: 32] = ref_lane(op, x[32*i +: 32], y[32*i +: 32]);
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [10:0] op, input logic [127:0] x,
                             input logic [127:0] y);
    @(negedge clk);
    start = 1'b1; opc = op; a = x; b = y;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 2000 && !seen; k++) begin
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic run_op(input logic [10:0] op, input logic [127:0] x,
                        input logic [127:0] y, input string why);
    bit seen;
    logic [127:0] e;
    e = ref_vec(op, x, y);
    pulse_start(op, x, y);
    wait_done(seen);
    check(seen, "R7", {why, " done seen"}, {127'b0, seen}, 128'd1);
    check(res == e, tag_of(op), why, res, e);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 8)
      0: return 32'd0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return $urandom % 8;
      4: return 32'd1;
      5: return 32'h7FFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin : watchdog
    wait (wd_hit);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [127:0] e, hold, ra, rb;
    logic [10:0] op;
    bit seen;
    void'($urandom(32'h5EED_0042));
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; start = 1'b0; opc = '0; a = '0; b = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !done, "R10", "busy/done after reset", {126'b0, busy, done}, 128'd0);
    check(res == '0, "R10", "result after reset", res, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 lane placement with distinct lanes
    run_op(11'h08B, {32'd1000, 32'd77, 32'd9, 32'hFFFF_FFFF},
                    {32'd10, 32'd7, 32'd3, 32'd2}, "divu lanes");
    run_op(11'h18B, {-32'sd7, 32'd7, -32'sd7, 32'd100},
                    {32'd2, -32'sd2, -32'sd2, 32'd7}, "divs truncation");
    // R2 modulo signs
    run_op(11'h78B, {-32'sd7, 32'd7, -32'sd7, 32'd100},
                    {32'd2, -32'sd2, -32'sd2, 32'd7}, "mods sign of dividend");
    run_op(11'h68B, {32'hFFFF_FFFF, 32'd13, 32'd5, 32'd3},
                    {32'd16, 32'd13, 32'd7, 32'd5}, "modu");
    // R3
    run_op(11'h289, {32'hFFFF_FFFF, 32'h8000_0000, 32'd3, 32'h1234_5678},
                    {32'hFFFF_FFFF, 32'd2, 32'd5, 32'h9ABC_DEF0}, "mulhu");
    run_op(11'h389, {32'hFFFF_FFFF, 32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF},
                    {32'hFFFF_FFFF, 32'd2, 32'h8000_0000, 32'h8000_0001}, "mulhs");
    // R4 fit limit at 32 bits
    run_op(11'h28B, {32'd1, 32'd1, 32'd5, 32'd2},
                    {32'd2, 32'd1, 32'd3, 32'd7}, "diveu fit/overflow");
    // R5 fit limit at 31 bits
    run_op(11'h38B, {32'd1, 32'd1, -32'sd1, 32'd1},
                    {32'd2, 32'd4, 32'd4, -32'sd4}, "dives fit/overflow");
    // R6 zero divisor and most-negative by -1
    run_op(11'h18B, {32'h8000_0000, 32'd5, -32'sd5, 32'd0},
                    {32'hFFFF_FFFF, 32'd0, 32'd0, 32'd0}, "R6 divs zero/ovf");
    check(res == '0, "R6", "divs zero/ovf lanes are zero", res, 128'd0);
    run_op(11'h78B, {32'h8000_0000, 32'd5, -32'sd5, 32'd9},
                    {32'hFFFF_FFFF, 32'd0, 32'd0, 32'd0}, "R6 mods zero/ovf");
    check(res == {32'd0, 32'd5, -32'sd5, 32'd9}, "R6", "mods zero divisor returns A",
          res, {32'd0, 32'd5, -32'sd5, 32'd9});
    run_op(11'h28B, {4{32'd9}}, '0, "R6 diveu zero divisor");

    // R7 done is one cycle and result holds while idle
    hold = res;
    @(negedge clk);
    check(!done, "R7", "done single cycle", {127'b0, done}, 128'd0);
    repeat (4) @(negedge clk);
    check(res == hold, "R7", "result holds while idle", res, hold);
    pulse_start(11'h08B, {4{32'd50}}, {4{32'd5}});
    check(busy, "R7", "busy after start", {127'b0, busy}, 128'd1);

    // R8 start while busy ignored
    repeat (3) @(negedge clk);
    start = 1'b1; opc = 11'h289; a = {4{32'hFFFF_FFFF}}; b = {4{32'hFFFF_FFFF}};
    @(negedge clk);
    start = 1'b0;
    wait_done(seen);
    e = {4{32'd10}};
    check(res == e, "R8", "start while busy ignored", res, e);
    @(negedge clk);
    @(negedge clk);
    check(!busy, "R8", "no second operation", {127'b0, busy}, 128'd0);

    // R9 unknown opcode ignored
    hold = res;
    pulse_start(11'h123, {4{32'd7}}, {4{32'd1}});
    check(!busy, "R9", "bad opcode no busy", {127'b0, busy}, 128'd0);
    repeat (3) @(negedge clk);
    check(res == hold && !done, "R9", "bad opcode leaves result", res, hold);

    // random mix over all opcodes (R1..R6)
    for (int t = 0; t < 48; t++) begin
      op = OPS[$urandom % 8];
      for (int i = 0; i < 4; i++) begin
        ra[32*i +: 32] = pick();
        rb[32*i +: 32] = pick();
      end
      run_op(op, ra, rb, "random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule